// File: doc/BRIEF.md
# Half-Bridge Gate Enable Sequencer

This block sits between a PWM source and the gate drivers of one inverter leg. It takes a high-side command, which is active high, and a low-side command, which is active low. It turns them into two gate enables that are never asserted together.

A command pair that asks for both sides, or for neither side, leaves the leg with both switches off. Whenever control passes from one switch to the other, the block holds both enables low for a programmable number of clock cycles. It does the same after a conflicting request is withdrawn.

An active-low shutdown input forces both enables low. An undervoltage-lockout flag also forces both enables low, and after the flag clears the block waits a full dead-time interval before it turns either switch on. A three-phase bridge uses three instances.

The dead time is set by `DT_CYCLES`, counted in clock cycles, with a minimum of 1. The default of 125 cycles gives a 1 µs gap at 125 MHz.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: With shutdown high, lockout low, `hi_cmd_i`=0 and `lo_cmd_ni`=0, `gate_lo_o` is the only enable that can be high. It rises on the first clock edge that samples this request while the dead-time counter is expired.
- R2: With shutdown high, lockout low, `hi_cmd_i`=1 and `lo_cmd_ni`=1, `gate_hi_o` is the only enable that can be high, under the same timing as R1.
- R3: With `hi_cmd_i`=0 and `lo_cmd_ni`=1 (no side requested), both enables are low one cycle after the request is sampled.
- R4: With `hi_cmd_i`=1 and `lo_cmd_ni`=0 (both sides requested), both enables are low one cycle later. The dead-time interval starts only once this conflict is withdrawn, so the new side turns on `DT_CYCLES` edges after the conflict ends.
- R5: While `sd_ni` is low, both enables are low one cycle after sampling, whatever the commands are.
- R6: `gate_lo_o` and `gate_hi_o` are never high in the same cycle.
- R7: When the request moves to the opposite side, the active enable drops on the next edge. The new side rises exactly `DT_CYCLES` edges after that, so both enables stay low for `DT_CYCLES` cycles.
- R8: If both enables have been low for at least `DT_CYCLES` cycles, a new side request is passed through on the next edge with no extra delay.
- R9: While `uvlo_i` is high, both enables are low one cycle after sampling. After `uvlo_i` falls, an enable rises on the `DT_CYCLES`-th edge that samples the lockout low, and not before.
- R10: Asynchronous reset drives both enables low at once and leaves the dead-time counter expired. A valid request sampled on the first edge after reset is therefore passed through on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cmd_i | input | 1 | High-side command, active high |
| lo_cmd_ni | input | 1 | Low-side command, active low |
| sd_ni | input | 1 | Shutdown, active low |
| uvlo_i | input | 1 | Undervoltage lockout flag, active high |
| gate_lo_o | output | 1 | Low-side gate enable |
| gate_hi_o | output | 1 | High-side gate enable |

## Verification
The properties assume that the command, shutdown and lockout inputs are already synchronous to `clk_i` and are sampled as stable levels at each rising edge. The decode and dead-time properties rely on this, and so does the one-cycle off latency. The stimulus therefore changes every input on the falling edge only, so no edge sees a change in flight. The dead-time windows are probed one cycle short of expiry, at expiry, and after an idle stretch longer than the window.

// File: rtl/hb_deadtime_pkg.sv
package hb_deadtime_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_LO   = 2'd1,
    REQ_HI   = 2'd2,
    REQ_BOTH = 2'd3
  } leg_req_e;
endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_deadtime_pkg::*;
(
  input  logic     hi_cmd_i,
  input  logic     lo_cmd_ni,
  input  logic     sd_ni,
  output leg_req_e req_o
);
  always_comb begin
    if (!sd_ni) begin
      req_o = REQ_NONE;
    end else begin
      unique case ({hi_cmd_i, ~lo_cmd_ni})
        2'b00:   req_o = REQ_NONE;
        2'b01:   req_o = REQ_LO;
        2'b10:   req_o = REQ_HI;
        default: req_o = REQ_BOTH;
      endcase
    end
  end
endmodule

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int unsigned DT_CYCLES = 125,
  parameter int unsigned CNT_W     = $clog2(DT_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // reset value zero: counter starts expired
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (step_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_deadtime_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_req_e req_i,
  input  logic     uvlo_i,
  input  logic     expired_i,
  output logic     load_o,
  output logic     step_o,
  output logic     gate_lo_o,
  output logic     gate_hi_o
);
  logic lo_q, hi_q;
  logic drop_lo, drop_hi, idle, turn_lo, turn_hi;

  always_comb begin
    drop_lo = lo_q && (req_i != REQ_LO);
    drop_hi = hi_q && (req_i != REQ_HI);
    idle    = !lo_q && !hi_q;
    // conflict keeps the window reloaded so dead time follows the overlap
    load_o  = uvlo_i || drop_lo || drop_hi || (idle && (req_i == REQ_BOTH));
    step_o  = idle && !load_o;
    turn_lo = step_o && expired_i && (req_i == REQ_LO);
    turn_hi = step_o && expired_i && (req_i == REQ_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else if (uvlo_i) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= drop_lo ? 1'b0 : (lo_q || turn_lo);
      hi_q <= drop_hi ? 1'b0 : (hi_q || turn_hi);
    end
  end

  assign gate_lo_o = lo_q;
  assign gate_hi_o = hi_q;
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_deadtime_pkg::*;
#(
  parameter int unsigned DT_CYCLES = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_cmd_i,
  input  logic lo_cmd_ni,
  input  logic sd_ni,
  input  logic uvlo_i,
  output logic gate_lo_o,
  output logic gate_hi_o
);
  localparam int unsigned CNT_W = $clog2(DT_CYCLES + 1);

  leg_req_e req;
  logic     load, step, expired;

  hb_cmd_decode u_decode (
    .hi_cmd_i  (hi_cmd_i),
    .lo_cmd_ni (lo_cmd_ni),
    .sd_ni     (sd_ni),
    .req_o     (req)
  );

  hb_dt_timer #(
    .DT_CYCLES (DT_CYCLES),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .expired_o (expired)
  );

  hb_gate_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .uvlo_i    (uvlo_i),
    .expired_i (expired),
    .load_o    (load),
    .step_o    (step),
    .gate_lo_o (gate_lo_o),
    .gate_hi_o (gate_hi_o)
  );
endmodule

// File: rtl/hb_deadtime_ctrl_chk.sv
module hb_deadtime_ctrl_chk #(
  parameter int unsigned DT_CYCLES = 125
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hi_cmd_i,
  input logic lo_cmd_ni,
  input logic sd_ni,
  input logic uvlo_i,
  input logic gate_lo_o,
  input logic gate_hi_o
);
  localparam int unsigned CW = $clog2(DT_CYCLES + 2);
  localparam logic [CW-1:0] SAT = CW'(DT_CYCLES + 1);
  localparam logic [CW-1:0] DTV = CW'(DT_CYCLES);

  logic [CW-1:0] off_cnt, uv_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt <= DTV;
      uv_cnt  <= DTV;
    end else begin
      off_cnt <= (gate_lo_o || gate_hi_o) ? '0 : ((off_cnt == SAT) ? SAT : off_cnt + 1'b1);
      uv_cnt  <= uvlo_i ? '0 : ((uv_cnt == SAT) ? SAT : uv_cnt + 1'b1);
    end
  end

  p_lo_only_on_request_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_lo_o |-> $past(sd_ni && !uvlo_i && !hi_cmd_i && !lo_cmd_ni));

  p_hi_only_on_request_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_hi_o |-> $past(sd_ni && !uvlo_i && hi_cmd_i && lo_cmd_ni));

  p_neither_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_cmd_i && lo_cmd_ni) |=> (!gate_lo_o && !gate_hi_o));

  p_conflict_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cmd_i && !lo_cmd_ni) |=> (!gate_lo_o && !gate_hi_o));

  p_shutdown_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_ni |=> (!gate_lo_o && !gate_hi_o));

  p_no_shoot_through_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_lo_o && gate_hi_o));

  p_dead_time_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_lo_o) || $rose(gate_hi_o)) |-> (off_cnt >= DTV));

  p_uvlo_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (!gate_lo_o && !gate_hi_o));

  p_uvlo_recover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_lo_o) || $rose(gate_hi_o)) |-> (uv_cnt >= DTV));
endmodule

bind hb_deadtime_ctrl hb_deadtime_ctrl_chk #(
  .DT_CYCLES (DT_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hi_cmd_i  (hi_cmd_i),
  .lo_cmd_ni (lo_cmd_ni),
  .sd_ni     (sd_ni),
  .uvlo_i    (uvlo_i),
  .gate_lo_o (gate_lo_o),
  .gate_hi_o (gate_hi_o)
);

// File: tb/hb_deadtime_ctrl_tb.sv
module hb_deadtime_ctrl_tb;
  localparam int unsigned DT = 8;
  localparam int NV = 23;

  typedef struct packed {
    logic       hi;
    logic       lo_n;
    logic       sd_n;
    logic       uv;
    logic [7:0] cyc;
    logic       e_lo;
    logic       e_hi;
    logic [7:0] rq;
  } vec_t;

  // hi, lo_n, sd_n, uv, edges, exp_lo, exp_hi, requirement
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,8'd2, 1'b0,1'b0,8'd3},  // R3 none after reset
    '{1'b0,1'b0,1'b1,1'b0,8'd1, 1'b1,1'b0,8'd1},  // R1 low side, expired counter
    '{1'b1,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b0,8'd7},  // R7 handover: low drops
    '{1'b1,1'b1,1'b1,1'b0,8'd7, 1'b0,1'b0,8'd7},  // R7 one short of window
    '{1'b1,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,8'd2},  // R2 high on at window end
    '{1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b0,8'd3},  // R3
    '{1'b0,1'b1,1'b1,1'b0,8'd10,1'b0,1'b0,8'd3},  // R3 idle past window
    '{1'b0,1'b0,1'b1,1'b0,8'd1, 1'b1,1'b0,8'd8},  // R8 direct follow
    '{1'b1,1'b0,1'b1,1'b0,8'd1, 1'b0,1'b0,8'd4},  // R4 conflict
    '{1'b1,1'b0,1'b1,1'b0,8'd20,1'b0,1'b0,8'd4},  // R4 long conflict
    '{1'b1,1'b1,1'b1,1'b0,8'd7, 1'b0,1'b0,8'd4},  // R4 window after conflict
    '{1'b1,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,8'd4},  // R4
    '{1'b1,1'b1,1'b0,1'b0,8'd1, 1'b0,1'b0,8'd5},  // R5 shutdown
    '{1'b0,1'b0,1'b0,1'b0,8'd12,1'b0,1'b0,8'd5},  // R5 request ignored
    '{1'b0,1'b0,1'b1,1'b0,8'd1, 1'b1,1'b0,8'd1},  // R1
    '{1'b0,1'b0,1'b1,1'b1,8'd1, 1'b0,1'b0,8'd9},  // R9 lockout
    '{1'b0,1'b0,1'b1,1'b1,8'd5, 1'b0,1'b0,8'd9},  // R9
    '{1'b0,1'b0,1'b1,1'b0,8'd7, 1'b0,1'b0,8'd9},  // R9 fresh window
    '{1'b0,1'b0,1'b1,1'b0,8'd1, 1'b1,1'b0,8'd9},  // R9
    '{1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b0,8'd3},  // R3
    '{1'b0,1'b1,1'b1,1'b0,8'd3, 1'b0,1'b0,8'd7},  // R7 gap inside window
    '{1'b1,1'b1,1'b1,1'b0,8'd4, 1'b0,1'b0,8'd7},  // R7 still blanked
    '{1'b1,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,8'd7}   // R7
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hi_cmd = 1'b0, lo_cmd_n = 1'b1, sd_n = 1'b1, uvlo = 1'b0;
  logic gate_lo, gate_hi;
  int checks = 0, failures = 0;
  logic overlap_seen = 1'b0;

  always #4 clk = ~clk;

  hb_deadtime_ctrl #(.DT_CYCLES(DT)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .hi_cmd_i  (hi_cmd),
    .lo_cmd_ni (lo_cmd_n),
    .sd_ni     (sd_n),
    .uvlo_i    (uvlo),
    .gate_lo_o (gate_lo),
    .gate_hi_o (gate_hi)
  );

  always @(negedge clk) if (rst_ni && gate_lo && gate_hi) overlap_seen = 1'b1;

  task automatic check(input int rq, input logic e_lo, input logic e_hi, input string tag);
    checks++;
    if (gate_lo !== e_lo || gate_hi !== e_hi) begin
      failures++;
      $display("FAIL R%0d %s: lo/hi=%b%b expected %b%b", rq, tag, gate_lo, gate_hi, e_lo, e_hi);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(10, 1'b0, 1'b0, "held in reset");             // R10
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      hi_cmd   = VECS[i].hi;
      lo_cmd_n = VECS[i].lo_n;
      sd_n     = VECS[i].sd_n;
      uvlo     = VECS[i].uv;
      repeat (int'(VECS[i].cyc)) @(posedge clk);
      @(negedge clk);
      check(int'(VECS[i].rq), VECS[i].e_lo, VECS[i].e_hi, $sformatf("vector %0d", i));
    end

    // R10 async reset while high side is on
    rst_ni = 1'b0;
    #1;
    check(10, 1'b0, 1'b0, "async reset clears enables");
    @(negedge clk);
    rst_ni   = 1'b1;
    hi_cmd   = 1'b0;
    lo_cmd_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(10, 1'b1, 1'b0, "first request after reset");

    // R6 never both enables
    checks++;
    if (overlap_seen) begin
      failures++;
      $display("FAIL R6 both enables seen high: actual 1 expected 0");
    end

    finish_run();
  end
endmodule